// File: doc/BRIEF.md
# Serial Code Lock Link

The block is a two-sided keyed lock whose halves run on one shared bit clock. The key side latches a password word from a bank of switch inputs when a start pulse arrives. It then sends that word one bit per clock on a single serial line, which stands in for a light link. The lock side shifts the arriving bits into a receive register of the same width. After the last bit it compares the rebuilt word with a reference code fixed at build time, and it raises a registered unlock flag only when the two are equal.

Both sides use one universal shift register design with a two-bit mode control: hold, shift toward the top bit, shift toward bit 0, and parallel load. The key side has three states. KEY_IDLE moves to KEY_LOAD on an accepted start. KEY_LOAD always moves to KEY_SEND. KEY_SEND returns to KEY_IDLE after `W` bits. The lock side also has three states. LOCK_WAIT moves to LOCK_RECV on the first incoming bit. LOCK_RECV moves to LOCK_EVAL after the last bit. LOCK_EVAL always returns to LOCK_WAIT. The word width `W` is a parameter (4 by default, 8 for the wider variant). `MSB_FIRST` selects the bit order on the line, and `LOCK_CODE` is the reference code.

Top module: `serial_code_lock`

## Requirements
- R1: While `rst_n` is low, every register is cleared at once: `unlock`, `tx_active`, `tx_line` and `rx_word` all read 0.
- R2: A start pulse accepted in KEY_IDLE puts the key in KEY_LOAD (mode 11). The switches are captured at the following edge, so any switch change after that edge has no effect on the frame.
- R3: With start sampled at edge e0, `tx_active` is high for exactly `W` cycles, from after e1 until e(W+1). During that time `tx_line` carries one word bit per cycle. `tx_line` is 0 whenever `tx_active` is low.
- R4: With `MSB_FIRST=1` the bits go out from bit `W-1` down to bit 0. With `MSB_FIRST=0` they go out from bit 0 up to bit `W-1`. In both orders the receiver rebuilds the same word.
- R5: After edge e(W+1), `rx_word` equals the switch word. `rx_word` changes only on edges where `tx_active` was high.
- R6: The match is the AND of the per-bit inverted XORs of `rx_word` and `LOCK_CODE`. `unlock` takes this result at edge e(W+2), so a difference in any single bit leaves it low.
- R7: `unlock` keeps its value until reset or until the edge that accepts the next start, and that edge clears it.
- R8: A start pulse that arrives while the key is in KEY_LOAD or KEY_SEND is ignored. The frame in flight completes unchanged and no extra frame follows.
- R9: If a start is accepted on the same edge as LOCK_EVAL, the clear wins: `unlock` stays 0, and the new frame runs to its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low master reset |
| start | input | 1 | Request to send the switch word as a new frame |
| switches | input | W | Password word set on the key side |
| tx_line | output | 1 | Serial line from key to lock |
| tx_active | output | 1 | High while a bit is on `tx_line` |
| rx_word | output | W | Word rebuilt by the lock side |
| unlock | output | 1 | Registered result of the code comparison |

## Verification
Two events can fall on the same edge: the key accepting a new start and the lock registering its comparison in LOCK_EVAL. The key is already back in KEY_IDLE on that edge. The bench runs a matching frame and raises start so that it is sampled exactly at edge e(W+2). It then expects `unlock` to read 0 after that edge, and 1 again once the new matching frame completes. A second overlap is a start that lands while a frame is in flight, together with a change of the switches. Here the bench expects the original word's result and no further frame.

// File: rtl/scl_pkg.sv
package scl_pkg;

    // Mode control of the universal shift register
    typedef enum logic [1:0] {
        SH_HOLD = 2'b00,   // keep contents
        SH_UP   = 2'b01,   // move toward the top bit, bit 0 from ser_lo
        SH_DOWN = 2'b10,   // move toward bit 0, top bit from ser_hi
        SH_LOAD = 2'b11    // take the parallel word
    } shift_mode_e;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'b00,
        KEY_LOAD = 2'b01,
        KEY_SEND = 2'b10
    } key_state_e;

    typedef enum logic [1:0] {
        LOCK_WAIT = 2'b00,
        LOCK_RECV = 2'b01,
        LOCK_EVAL = 2'b10
    } lock_state_e;

endpackage

// File: rtl/scl_univ_shift_reg.sv
module scl_univ_shift_reg
    import scl_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  shift_mode_e  mode,
    input  logic [W-1:0] par_in,
    input  logic         ser_lo,
    input  logic         ser_hi,
    output logic [W-1:0] q
);

    logic [W-1:0] up_word;
    logic [W-1:0] down_word;

    // Per-bit neighbour selection for both shift directions
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign up_word[i] = ser_lo;
        end else begin : g_low_mid
            assign up_word[i] = q[i-1];
        end
        if (i == W-1) begin : g_high
            assign down_word[i] = ser_hi;
        end else begin : g_high_mid
            assign down_word[i] = q[i+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (mode)
                SH_HOLD: q <= q;
                SH_UP:   q <= up_word;
                SH_DOWN: q <= down_word;
                SH_LOAD: q <= par_in;
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/scl_word_match.sv
module scl_word_match #(
    parameter int W = 4
) (
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    output logic         equal
);

    logic [W-1:0] bit_same;

    // One inverted XOR per bit pair
    for (genvar i = 0; i < W; i++) begin : g_xnor
        assign bit_same[i] = ~(word_a[i] ^ word_b[i]);
    end

    assign equal = &bit_same;

endmodule

// File: rtl/scl_key_tx.sv
module scl_key_tx
    import scl_pkg::*;
#(
    parameter int W         = 4,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] switches,
    output logic         frame_begin,
    output logic         tx_active,
    output logic         tx_line
);

    localparam int          CW        = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);
    localparam shift_mode_e SEND_MODE = MSB_FIRST ? SH_UP : SH_DOWN;
    localparam int          OUT_IDX   = MSB_FIRST ? (W - 1) : 0;
    localparam logic [W-1:0] OUT_MASK = W'(1) << OUT_IDX;

    key_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    shift_mode_e   mode;
    logic [W-1:0]  word_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            KEY_IDLE: begin
                if (start) begin
                    state_d = KEY_LOAD;
                end
            end
            KEY_LOAD: begin
                state_d = KEY_SEND;
                cnt_d   = '0;
            end
            KEY_SEND: begin
                if (cnt_q == LAST_BIT) begin
                    state_d = KEY_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = KEY_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        mode        = SH_HOLD;
        frame_begin = 1'b0;
        tx_active   = 1'b0;
        tx_line     = 1'b0;
        unique case (state_q)
            KEY_IDLE: frame_begin = start;
            KEY_LOAD: mode = SH_LOAD;
            KEY_SEND: begin
                mode      = SEND_MODE;
                tx_active = 1'b1;
                tx_line   = |(word_q & OUT_MASK);
            end
            default: mode = SH_HOLD;
        endcase
    end

    scl_univ_shift_reg #(.W(W)) u_key_sr (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .par_in (switches),
        .ser_lo (1'b0),
        .ser_hi (1'b0),
        .q      (word_q)
    );

endmodule

// File: rtl/scl_lock_rx.sv
module scl_lock_rx
    import scl_pkg::*;
#(
    parameter int           W         = 4,
    parameter bit           MSB_FIRST = 1'b1,
    parameter logic [W-1:0] LOCK_CODE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_begin,
    input  logic         tx_active,
    input  logic         tx_line,
    output logic [W-1:0] rx_word,
    output logic         unlock
);

    localparam int            CW        = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_BIT  = CW'(W - 1);
    localparam shift_mode_e   RECV_MODE = MSB_FIRST ? SH_UP : SH_DOWN;

    lock_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    shift_mode_e   mode;
    logic          evaluate;
    logic          code_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LOCK_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LOCK_WAIT: begin
                if (tx_active) begin
                    if (LAST_BIT == '0) begin
                        state_d = LOCK_EVAL;
                        cnt_d   = '0;
                    end else begin
                        state_d = LOCK_RECV;
                        cnt_d   = CW'(1);
                    end
                end
            end
            LOCK_RECV: begin
                if (tx_active) begin
                    if (cnt_q == LAST_BIT) begin
                        state_d = LOCK_EVAL;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            LOCK_EVAL: begin
                state_d = LOCK_WAIT;
            end
            default: begin
                state_d = LOCK_WAIT;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        mode     = SH_HOLD;
        evaluate = 1'b0;
        unique case (state_q)
            LOCK_WAIT: mode = tx_active ? RECV_MODE : SH_HOLD;
            LOCK_RECV: mode = tx_active ? RECV_MODE : SH_HOLD;
            LOCK_EVAL: evaluate = 1'b1;
            default:   mode = SH_HOLD;
        endcase
    end

    scl_univ_shift_reg #(.W(W)) u_lock_sr (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .par_in ('0),
        .ser_lo (tx_line),
        .ser_hi (tx_line),
        .q      (rx_word)
    );

    scl_word_match #(.W(W)) u_match (
        .word_a (rx_word),
        .word_b (LOCK_CODE),
        .equal  (code_ok)
    );

    // Unlock flag: a new frame clears it ahead of any evaluation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlock <= 1'b0;
        end else if (frame_begin) begin
            unlock <= 1'b0;
        end else if (evaluate) begin
            unlock <= code_ok;
        end
    end

endmodule

// File: rtl/serial_code_lock.sv
module serial_code_lock #(
    parameter int           W         = 4,
    parameter bit           MSB_FIRST = 1'b1,
    parameter logic [W-1:0] LOCK_CODE = W'(10)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] switches,
    output logic         tx_line,
    output logic         tx_active,
    output logic [W-1:0] rx_word,
    output logic         unlock
);

    logic frame_begin;

    scl_key_tx #(
        .W         (W),
        .MSB_FIRST (MSB_FIRST)
    ) u_key (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .switches    (switches),
        .frame_begin (frame_begin),
        .tx_active   (tx_active),
        .tx_line     (tx_line)
    );

    scl_lock_rx #(
        .W         (W),
        .MSB_FIRST (MSB_FIRST),
        .LOCK_CODE (LOCK_CODE)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_begin (frame_begin),
        .tx_active   (tx_active),
        .tx_line     (tx_line),
        .rx_word     (rx_word),
        .unlock      (unlock)
    );

endmodule

// File: rtl/scl_lock_checker.sv
module scl_lock_checker #(
    parameter int           W         = 4,
    parameter logic [W-1:0] LOCK_CODE = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_begin,
    input logic         tx_active,
    input logic         tx_line,
    input logic [W-1:0] rx_word,
    input logic         unlock
);

    // R1: registers read cleared while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (!unlock && !tx_active && !tx_line && rx_word == '0)
                else $error("reset state not clear");
        end
    end

    // R3: the line rests low outside a frame
    assert_idle_line_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !tx_line);

    // R2: one load cycle separates acceptance and the first bit
    assert_load_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_begin |=> !tx_active ##1 tx_active);

    // R7: accepted start clears the flag
    assert_unlock_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_begin |=> !unlock);

    // R6: the flag only rises on a matching word
    assert_unlock_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> (rx_word == LOCK_CODE));

    // R7: flag steady apart from clear and evaluation
    assert_unlock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_begin && !$fell(tx_active)) |=> $stable(unlock));

    // R5: received word only moves with a bit on the line
    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> $stable(rx_word));

endmodule

bind serial_code_lock scl_lock_checker #(
    .W         (W),
    .LOCK_CODE (LOCK_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_begin (frame_begin),
    .tx_active   (tx_active),
    .tx_line     (tx_line),
    .rx_word     (rx_word),
    .unlock      (unlock)
);

// File: tb/serial_code_lock_tb.sv
`timescale 1ns/1ps
module serial_code_lock_tb;

    localparam int         W    = 4;
    localparam logic [3:0] CODE = 4'hA;

    // {expected unlock, switch word}
    localparam logic [4:0] VECS [10] = '{
        5'h1A, 5'h00, 5'h0F, 5'h0B, 5'h02,
        5'h08, 5'h0E, 5'h05, 5'h1A, 5'h1A
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] switches = '0;
    logic         tx_line, tx_active, unlock;
    logic [W-1:0] rx_word;
    logic         tx_line_lsb, tx_active_lsb, unlock_lsb;
    logic [W-1:0] rx_word_lsb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    serial_code_lock #(.W(W), .MSB_FIRST(1'b1), .LOCK_CODE(CODE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .switches(switches),
        .tx_line(tx_line), .tx_active(tx_active), .rx_word(rx_word), .unlock(unlock)
    );

    serial_code_lock #(.W(W), .MSB_FIRST(1'b0), .LOCK_CODE(CODE)) u_dut_lsb (
        .clk(clk), .rst_n(rst_n), .start(start), .switches(switches),
        .tx_line(tx_line_lsb), .tx_active(tx_active_lsb), .rx_word(rx_word_lsb),
        .unlock(unlock_lsb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Full frame; returns after the edge that registers the result
    task automatic run_frame(input logic [3:0] sw, input logic exp_unlock);
        @(negedge clk);
        switches = sw;
        start    = 1'b1;
        @(negedge clk);                       // e0 passed
        start = 1'b0;
        chk("R7 clear at accepted start", unlock, 0);
        chk("R2 load cycle idle line", tx_active, 0);
        @(negedge clk);                       // e1 passed
        for (int b = 0; b < W; b++) begin
            chk("R3 active during bit", tx_active, 1);
            chk("R4 msb-first bit", tx_line, sw[W-1-b]);
            chk("R4 lsb-first bit", tx_line_lsb, sw[b]);
            @(negedge clk);
        end
        chk("R3 active ends after W bits", tx_active, 0);
        chk("R3 idle line low", tx_line, 0);
        chk("R5 rebuilt word", rx_word, sw);
        chk("R4 lsb variant rebuilt word", rx_word_lsb, sw);
        @(negedge clk);                       // evaluation edge passed
        chk("R6 unlock result", unlock, exp_unlock);
        chk("R4 lsb variant unlock", unlock_lsb, exp_unlock);
    endtask

    initial begin
        wait_neg(3);
        chk("R1 reset unlock", unlock, 0);
        chk("R1 reset tx_active", tx_active, 0);
        chk("R1 reset tx_line", tx_line, 0);
        chk("R1 reset rx_word", rx_word, 0);
        rst_n = 1'b1;
        wait_neg(2);

        // Vector table walk
        for (int v = 0; v < 10; v++) begin
            run_frame(VECS[v][3:0], VECS[v][4]);
        end

        // R7: result held while idle
        wait_neg(5);
        chk("R7 unlock held while idle", unlock, 1);

        // R2 + R8: switch change and start while busy
        run_frame(4'h3, 1'b0);
        @(negedge clk);
        switches = CODE;
        start    = 1'b1;
        @(negedge clk);                       // e0
        start = 1'b0;
        @(negedge clk);                       // e1: word captured
        switches = 4'h0;
        start    = 1'b1;                      // sampled at e2, key busy
        @(negedge clk);
        start = 1'b0;
        wait_neg(4);                          // e6
        chk("R2 switches after capture ignored", unlock, 1);
        chk("R8 busy start frame intact", rx_word, CODE);
        for (int k = 0; k < 6; k++) begin
            chk("R8 no extra frame", tx_active, 0);
            @(negedge clk);
        end
        chk("R8 unlock kept", unlock, 1);

        // R9: accepted start on the evaluation edge
        run_frame(4'h0, 1'b0);
        @(negedge clk);
        switches = CODE;
        start    = 1'b1;
        @(negedge clk);                       // e0
        start = 1'b0;
        wait_neg(4);                          // after e4
        start = 1'b1;                         // sampled at e5? key busy: delay one more
        @(negedge clk);                       // after e5 (ignored start at e5)
        start = 1'b1;                         // sampled at e6 = evaluation edge
        @(negedge clk);                       // after e6
        start = 1'b0;
        chk("R9 clear wins over evaluation", unlock, 0);
        wait_neg(6);
        chk("R9 new frame result", unlock, 1);

        // R1: reset while unlocked and mid-frame
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears unlock", unlock, 0);
        rst_n = 1'b1;
        @(negedge clk);
        switches = 4'hF;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_neg(3);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-frame tx_active", tx_active, 0);
        chk("R1 reset mid-frame tx_line", tx_line, 0);
        chk("R1 reset mid-frame rx_word", rx_word, 0);
        rst_n = 1'b1;
        wait_neg(2);
        run_frame(CODE, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule